// File: doc/BRIEF.md
# Paged Memory Window Controller

This block sits on a Z80 host bus and claims two windows at the top of the memory map. The lower window covers E300h to EFFFh, which leaves the host's memory-mapped I/O at E000h to E2FFh alone. The upper window covers F000h to FFFFh. Each window shows one 4 KB page of either a 512 KB flash or a 32 KB SRAM. The page comes from a register that software writes through I/O ports. During a window access the block drives an 8-bit upper-address bus that carries the page number and address bit 11.

The block also watches the host's own bank-switch port writes and keeps two flags. A "disable" flag is set while the host maps its DRAM over the upper area. An "inhibit" flag is set while the host blocks the upper area entirely. While either flag is set, the block claims nothing.

For the slow host type (mode 0), the floppy controller's data-request line is merged into flash address bit 10. This lets boot code branch on data-ready with no polling loop. A mode jumper is captured during reset and can be read back by software.

Top module: `paged_window_ctl`

## Requirements
- R1: The lower window responds only to memory cycles (mreqN low together with rdN or wrN low) at E300h..EFFFh. Addresses E000h..E2FFh and below never assert a chip select, and neither does mreqN low with both strobes high.
- R2: The upper window responds to memory cycles at F000h..FFFFh.
- R3: An I/O write to port 60h stores data bits [6:0] as the lower page, and a write to 61h stores them as the upper page. An I/O read of either port returns the page with bit 7 zero. A new page applies to the next window access.
- R4: Bit 0 of port 62h picks the device for both windows: 0 selects flash (romCsN low), 1 selects SRAM (ramCsN low). The other bits are ignored. The two chip selects are never low together.
- R5: An I/O read of port 63h returns the latched mode in bits [2:0], with zeros above. Writes to 63h have no effect.
- R6: During an active window access, upAddr equals {page[6:0], A11}. At all other times it is 0.
- R7: After reset, the lower page is 2, the device select is flash, and both host flags are clear. The upper page is 0 if the jumper read 0 during reset, and 1 otherwise.
- R8: I/O writes to host ports update the flags: E1h sets disable, E3h or E4h clears disable, E5h sets inhibit, E6h clears inhibit. I/O reads of these ports change nothing. While either flag is set, both chip selects stay high.
- R9: Inhibit dominates disable. Clearing disable while inhibit is set leaves the windows suppressed, and clearing inhibit while disable is set also leaves them suppressed.
- R10: romA10 is 1 when the latched mode is 0 and drq is 1. Otherwise romA10 follows A10. ramA10 always follows A10.
- R11: dataOe is 1 only while iorqN and rdN are both low and A[7:0] is in 60h..63h. Memory reads and I/O writes never raise it.
- R12: Changes on the mode jumper after reset has been released affect neither the readback nor the A10 steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (16 MHz in the system) |
| rstN | input | 1 | Active-low asynchronous reset; the mode is captured while it is low |
| addr | input | 16 | Z80 address bus |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Z80 data bus as seen by the block |
| dataOut | output | 8 | Register readback data |
| dataOe | output | 1 | Enable for driving dataOut onto the Z80 bus |
| modeIn | input | 3 | Host mode jumper |
| drq | input | 1 | Floppy controller data request |
| romCsN | output | 1 | Flash chip select, active low |
| ramCsN | output | 1 | SRAM chip select, active low |
| upAddr | output | 8 | Upper address to flash/SRAM: {page, A11} |
| romA10 | output | 1 | Flash address bit 10 with data-request steering |
| ramA10 | output | 1 | SRAM address bit 10 |

## Verification
The bench uses the default parameters: a 7-bit page, a 3-bit mode, the DRQ-steering mode set to 0, and a lower-page reset value of 2. With these values, page 0 and page 127 can both be reached through the ports, and every window edge (DFFFh, E000h, E2FFh, E300h, EFFFh, F000h, FFFFh) can be probed at its real address. The block is reset twice, once with jumper 0 and once with jumper 3. This exercises both upper-page reset values and both A10 behaviours. All four on/off combinations of the disable and inhibit flags are walked through, in both orders of release.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // Write strobes from the decoder to the register file
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic wrRamSel;
    logic setDis;
    logic clrDis;
    logic setInh;
    logic clrInh;
  } ioStrobes_t;

  typedef enum logic [1:0] {
    RD_LOW    = 2'd0,
    RD_HIGH   = 2'd1,
    RD_RAMSEL = 2'd2,
    RD_MODE   = 2'd3
  } rdSel_e;
endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter logic [7:0] REG_BASE  = 8'h60,
  parameter logic [7:0] HOST_BASE = 8'hE0,
  parameter logic [7:0] LOW_FIRST = 8'hE3
) (
  input  logic [15:0] addr,
  input  logic        mreqN,
  input  logic        iorqN,
  input  logic        rdN,
  input  logic        wrN,
  output ioStrobes_t  strb,
  output logic        lowHit,
  output logic        highHit,
  output logic        regRdEn,
  output rdSel_e      rdSel
);
  localparam logic [7:0] PORT_DIS_SET = HOST_BASE + 8'd1;
  localparam logic [7:0] PORT_DIS_CLA = HOST_BASE + 8'd3;
  localparam logic [7:0] PORT_DIS_CLB = HOST_BASE + 8'd4;
  localparam logic [7:0] PORT_INH_SET = HOST_BASE + 8'd5;
  localparam logic [7:0] PORT_INH_CLR = HOST_BASE + 8'd6;

  logic       ioWr, ioRd, memCyc, regHit;
  logic [7:0] port;

  always_comb begin
    port   = addr[7:0];
    ioWr   = !iorqN && !wrN;
    ioRd   = !iorqN && !rdN;
    memCyc = !mreqN && (!rdN || !wrN);
    regHit = (port[7:2] == REG_BASE[7:2]);

    strb.wrLow    = ioWr && (port == REG_BASE);
    strb.wrHigh   = ioWr && (port == REG_BASE + 8'd1);
    strb.wrRamSel = ioWr && (port == REG_BASE + 8'd2);
    strb.setDis   = ioWr && (port == PORT_DIS_SET);
    strb.clrDis   = ioWr && ((port == PORT_DIS_CLA) || (port == PORT_DIS_CLB));
    strb.setInh   = ioWr && (port == PORT_INH_SET);
    strb.clrInh   = ioWr && (port == PORT_INH_CLR);

    lowHit  = memCyc && (addr[15:12] == 4'hE) && (addr[15:8] >= LOW_FIRST);
    highHit = memCyc && (addr[15:12] == 4'hF);
    regRdEn = ioRd && regHit;
    rdSel   = rdSel_e'(port[1:0]);
  end
endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int PAGE_W  = 7,
  parameter int MODE_W  = 3,
  parameter int DATA_W  = 8,
  parameter int LOW_RST = 2,
  parameter logic [MODE_W-1:0] DRQ_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              addr11,
  input  logic              addr10,
  input  logic              drq,
  input  ioStrobes_t        strb,
  input  logic              lowHit,
  input  logic              highHit,
  input  logic              regRdEn,
  input  rdSel_e            rdSel,
  output logic              romCsN,
  output logic              ramCsN,
  output logic [PAGE_W:0]   upAddr,
  output logic              romA10,
  output logic              ramA10,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [MODE_W-1:0] modeReg;
  logic [PAGE_W-1:0] lowPage, highPage, selPage;
  logic              ramSel, romDis, romInh, winOn;
  logic              unusedData;

  assign unusedData = ^dataIn[DATA_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= modeIn;
      lowPage  <= PAGE_W'(LOW_RST);
      highPage <= (modeIn == DRQ_MODE) ? '0 : PAGE_W'(1);
      ramSel   <= 1'b0;
      romDis   <= 1'b0;
      romInh   <= 1'b0;
    end else begin
      if (strb.wrLow)    lowPage  <= dataIn[PAGE_W-1:0];
      if (strb.wrHigh)   highPage <= dataIn[PAGE_W-1:0];
      if (strb.wrRamSel) ramSel   <= dataIn[0];
      if (strb.setDis)      romDis <= 1'b1;
      else if (strb.clrDis) romDis <= 1'b0;
      if (strb.setInh)      romInh <= 1'b1;
      else if (strb.clrInh) romInh <= 1'b0;
    end
  end

  always_comb begin
    winOn   = (lowHit || highHit) && !romInh && !romDis;
    romCsN  = !(winOn && !ramSel);
    ramCsN  = !(winOn && ramSel);
    selPage = highHit ? highPage : lowPage;
    upAddr  = winOn ? {selPage, addr11} : '0;
    romA10  = ((modeReg == DRQ_MODE) && drq) ? 1'b1 : addr10;
    ramA10  = addr10;
    dataOe  = regRdEn;
    unique case (rdSel)
      RD_LOW:    dataOut = DATA_W'(lowPage);
      RD_HIGH:   dataOut = DATA_W'(highPage);
      RD_RAMSEL: dataOut = DATA_W'(ramSel);
      default:   dataOut = DATA_W'(modeReg);
    endcase
  end

  // R3: a page write lands in the register on the following edge
  a_r3_low_page_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLow |=> (lowPage == $past(dataIn[PAGE_W-1:0])));
  // R8: a disable-set strobe leaves the flag set
  a_r8_dis_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDis |=> romDis);
  // R9: inhibit survives a disable-clear strobe
  a_r9_inh_holds: assert property (@(posedge clk) disable iff (!rstN)
    (romInh && strb.clrDis && !strb.clrInh) |=> romInh);
  // R12: mode stays fixed outside reset
  a_r12_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeReg));
endmodule

// File: rtl/paged_window_ctl.sv
module paged_window_ctl
  import pwc_pkg::*;
#(
  parameter int PAGE_W  = 7,
  parameter int MODE_W  = 3,
  parameter int LOW_RST = 2,
  parameter logic [MODE_W-1:0] DRQ_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       addr,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              drq,
  output logic              romCsN,
  output logic              ramCsN,
  output logic [PAGE_W:0]   upAddr,
  output logic              romA10,
  output logic              ramA10
);
  ioStrobes_t strb;
  logic       lowHit, highHit, regRdEn;
  rdSel_e     rdSel;

  pwc_ctrl u_ctrl (
    .addr(addr), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .strb(strb), .lowHit(lowHit), .highHit(highHit),
    .regRdEn(regRdEn), .rdSel(rdSel)
  );

  pwc_datapath #(
    .PAGE_W(PAGE_W), .MODE_W(MODE_W), .DATA_W(8),
    .LOW_RST(LOW_RST), .DRQ_MODE(DRQ_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .dataIn(dataIn),
    .addr11(addr[11]), .addr10(addr[10]), .drq(drq), .strb(strb),
    .lowHit(lowHit), .highHit(highHit), .regRdEn(regRdEn), .rdSel(rdSel),
    .romCsN(romCsN), .ramCsN(ramCsN), .upAddr(upAddr),
    .romA10(romA10), .ramA10(ramA10), .dataOut(dataOut), .dataOe(dataOe)
  );

  // R1: the host I/O gap and everything below is never claimed
  a_r1_gap_free: assert property (@(posedge clk) disable iff (!rstN)
    (addr[15:8] < 8'hE3) |-> (romCsN && ramCsN));
  // R4: one device at a time
  a_r4_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    !(!romCsN && !ramCsN));
  // R11: readback only on I/O reads
  a_r11_oe_io_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!iorqN && !rdN));
  // R10: SRAM bit 10 never steered
  a_r10_ram_a10: assert property (@(posedge clk) disable iff (!rstN)
    ramA10 == addr[10]);
endmodule

// File: tb/paged_window_ctl_bench.sv
`timescale 1ns/1ps
module paged_window_ctl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] addr;
  logic        mreqN, iorqN, rdN, wrN;
  logic [7:0]  dataIn, dataOut, upAddr;
  logic        dataOe, drq, romCsN, ramCsN, romA10, ramA10;
  logic [2:0]  modeIn;

  always #5 clk = ~clk;

  paged_window_ctl u_paged_window_ctl (
    .clk(clk), .rstN(rstN), .addr(addr), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .modeIn(modeIn), .drq(drq), .romCsN(romCsN), .ramCsN(ramCsN),
    .upAddr(upAddr), .romA10(romA10), .ramA10(ramA10)
  );

  typedef struct {
    string       req;
    logic [20:0] exp;
    logic [20:0] mask;
  } item_t;

  item_t q[$];
  event  evSample;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  // Reference state kept from the requirements
  logic [6:0] mLo, mHi;
  logic       mRam, mDis, mInh;
  logic [2:0] mMode;

  // Monitor: pops one expectation per sample event and compares
  initial begin
    forever begin
      @(evSample);
      #1;
      begin
        item_t it;
        logic [20:0] obs;
        it  = q.pop_front();
        obs = {dataOe, dataOut, romCsN, ramCsN, romA10, ramA10, upAddr};
        checks++;
        if (((obs ^ it.exp) & it.mask) != 0) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h mask=%h", it.req, obs, it.exp, it.mask);
        end
      end
    end
  end

  task automatic push(string req, logic [20:0] e, logic [20:0] m);
    item_t it;
    it.req = req; it.exp = e; it.mask = m;
    q.push_back(it);
    -> evSample;
    #3;
  endtask

  task automatic idle();
    mreqN = 1; iorqN = 1; rdN = 1; wrN = 1;
  endtask

  task automatic doReset(logic [2:0] m);
    @(negedge clk);
    idle(); modeIn = m; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    mMode = m; mLo = 7'd2; mHi = (m == 3'd0) ? 7'd0 : 7'd1;
    mRam = 0; mDis = 0; mInh = 0;
  endtask

  task automatic ioWr(logic [7:0] port, logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; dataIn = d; iorqN = 0; wrN = 0;
    @(negedge clk);
    @(negedge clk);
    idle();
  endtask

  // Memory cycle: expected outputs derived from the reference state
  task automatic memCheck(string req, logic [15:0] a, logic doRd, logic doWr);
    logic inWin, act;
    logic [6:0] pg;
    logic [20:0] e;
    @(negedge clk);
    addr = a; mreqN = 0; rdN = !doRd; wrN = !doWr;
    inWin = ((a >= 16'hE300) && (a <= 16'hEFFF)) || (a >= 16'hF000);
    act   = inWin && (doRd || doWr) && !mDis && !mInh;
    pg    = (a >= 16'hF000) ? mHi : mLo;
    e[20]    = 1'b0;
    e[19:12] = 8'h00;
    e[11]    = !(act && !mRam);
    e[10]    = !(act && mRam);
    e[9]     = ((mMode == 3'd0) && drq) ? 1'b1 : a[10];
    e[8]     = a[10];
    e[7:0]   = act ? {pg, a[11]} : 8'h00;
    push(req, e, 21'h100FFF);
    idle();
  endtask

  task automatic ioRdCheck(string req, logic [7:0] port, logic expOe, logic [7:0] expD);
    @(negedge clk);
    addr = {8'hE0, port}; iorqN = 0; rdN = 0;
    push(req, {expOe, expD, 12'h000}, expOe ? 21'h1FF000 : 21'h100000);
    idle();
  endtask

  initial begin
    rstN = 0; drq = 0; addr = 0; dataIn = 0; modeIn = 0;
    idle();
    doReset(3'd0);

    // Reset state
    ioRdCheck("R7 lower page reset", 8'h60, 1, 8'h02);
    ioRdCheck("R7 upper page reset mode0", 8'h61, 1, 8'h00);
    ioRdCheck("R7 ram select reset", 8'h62, 1, 8'h00);
    ioRdCheck("R5 mode readback 0", 8'h63, 1, 8'h00);
    ioRdCheck("R11 no oe for other port", 8'hDF, 0, 8'h00);
    ioRdCheck("R11 no oe for 64h", 8'h64, 0, 8'h00);

    // Window boundaries
    memCheck("R1 DFFF not claimed", 16'hDFFF, 1, 0);
    memCheck("R1 E000 not claimed", 16'hE000, 1, 0);
    memCheck("R1 E2FF not claimed", 16'hE2FF, 1, 0);
    memCheck("R1 E300 claimed", 16'hE300, 1, 0);
    memCheck("R1 EFFF claimed", 16'hEFFF, 1, 0);
    memCheck("R1 write cycle claimed", 16'hE8AB, 0, 1);
    memCheck("R1 no strobe not claimed", 16'hE800, 0, 0);
    memCheck("R2 F000 claimed", 16'hF000, 1, 0);
    memCheck("R2 FFFF claimed", 16'hFFFF, 1, 0);
    memCheck("R11 R2 memory read no oe", 16'hF060, 1, 0);

    // DRQ steering in mode 0
    drq = 1;
    memCheck("R10 drq forces romA10", 16'hE300, 1, 0);
    memCheck("R10 drq outside window", 16'h1000, 1, 0);
    drq = 0;
    memCheck("R10 A10 passthrough", 16'hF400, 1, 0);

    // Page registers
    ioWr(8'h60, 8'hFF); mLo = 7'h7F;
    ioWr(8'h61, 8'hD5); mHi = 7'h55;
    ioRdCheck("R3 lower page readback", 8'h60, 1, 8'h7F);
    ioRdCheck("R3 upper page readback", 8'h61, 1, 8'h55);
    memCheck("R6 R3 lower page A11=0", 16'hE400, 1, 0);
    memCheck("R6 R3 lower page A11=1", 16'hEC00, 1, 0);
    memCheck("R6 R3 upper page A11=1", 16'hF800, 1, 0);
    ioWr(8'h60, 8'h00); mLo = 7'h00;
    memCheck("R3 lower page zero", 16'hE900, 1, 0);

    // Device select
    ioWr(8'h62, 8'h01); mRam = 1;
    memCheck("R4 sram lower", 16'hE300, 1, 0);
    memCheck("R4 sram upper", 16'hFC00, 0, 1);
    ioRdCheck("R4 ram select readback", 8'h62, 1, 8'h01);
    ioWr(8'h62, 8'hFE); mRam = 0;
    memCheck("R4 upper bits ignored flash", 16'hF000, 1, 0);

    // Mode register is read-only
    ioWr(8'h63, 8'h07);
    ioRdCheck("R5 write to 63h ignored", 8'h63, 1, 8'h00);

    // Host flag tracking
    ioWr(8'hE1, 8'h00); mDis = 1;
    memCheck("R8 E1 disables", 16'hF000, 1, 0);
    ioWr(8'hE3, 8'h00); mDis = 0;
    memCheck("R8 E3 re-enables", 16'hF000, 1, 0);
    ioWr(8'hE1, 8'h00); mDis = 1;
    ioWr(8'hE4, 8'h00); mDis = 0;
    memCheck("R8 E4 re-enables", 16'hE300, 1, 0);
    ioRdCheck("R8 read of E1h", 8'hE1, 0, 8'h00);
    memCheck("R8 read of E1h ignored", 16'hE300, 1, 0);
    ioWr(8'hE5, 8'h00); mInh = 1;
    memCheck("R8 E5 inhibits", 16'hE300, 1, 0);
    ioWr(8'hE6, 8'h00); mInh = 0;
    memCheck("R8 E6 releases", 16'hE300, 1, 0);
    ioWr(8'hE5, 8'h00); mInh = 1;
    ioWr(8'hE1, 8'h00); mDis = 1;
    memCheck("R9 both set suppressed", 16'hF000, 1, 0);
    ioWr(8'hE3, 8'h00); mDis = 0;
    memCheck("R9 inhibit dominates", 16'hF000, 1, 0);
    ioWr(8'hE1, 8'h00); mDis = 1;
    ioWr(8'hE6, 8'h00); mInh = 0;
    memCheck("R9 disable still holds", 16'hF000, 1, 0);
    ioWr(8'hE4, 8'h00); mDis = 0;
    memCheck("R9 both clear active", 16'hF000, 1, 0);

    // Second reset with another jumper
    doReset(3'd3);
    ioRdCheck("R7 upper page reset other mode", 8'h61, 1, 8'h01);
    ioRdCheck("R7 lower page after second reset", 8'h60, 1, 8'h02);
    memCheck("R7 flags cleared by reset", 16'hF000, 1, 0);
    modeIn = 3'd0;
    ioRdCheck("R12 jumper change ignored", 8'h63, 1, 8'h03);
    drq = 1;
    memCheck("R12 R10 no steering other mode", 16'hF000, 1, 0);
    memCheck("R10 A10 high other mode", 16'hF400, 1, 0);
    drq = 0;

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule